// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block is the interrupt front end of a peripheral with several request sources (two by default). It sits in a priority chain of devices. An enable input comes from the next device up the chain, and an enable output goes to the next device down. A device only requests or answers an acknowledge while its enable input is high. While it has anything pending or in service, it pulls its enable output low. Inside the device, source 0 has the highest priority and each higher index has less.

When the CPU acknowledges, the winning source drives its own programmed 8-bit vector onto the vector bus in the same cycle, with bit 0 always forced to 0. The source is then marked in service. A higher-priority source can still interrupt it, but a lower one cannot.

End of service is found without any dedicated CPU signal. The block watches the opcode fetches on the data bus. When it sees the two-byte return-from-interrupt sequence, the highest-priority source still in service leaves service, provided the chain enable input is high.

Top module: `ichain_ctrl`

## Requirements
- R1: After reset no source is pending or in service: `irq_o` is 0, `vec_oe_o` is 0, and `ien_o` follows `ien_i`.
- R2: A one-cycle pulse on `req_i[i]` makes source i pending from the next clock edge. While `ien_i` is high, `irq_o` rises and `ien_o` falls at that edge.
- R3: `ien_o` is 1 only when `ien_i` is 1 and no source is pending or in service. `irq_o` is 0 whenever `ien_i` is 0.
- R4: In a cycle with `iack_i` high and `ien_i` high, the eligible source with the lowest index wins. Its vector appears on `vec_o` with `vec_oe_o` high in that same cycle. At the next edge it leaves pending and enters service.
- R5: A source is blocked while it or any lower-index source is in service. A blocked source neither raises `irq_o` nor answers an acknowledge.
- R6: A pending source with a lower index than every in-service source raises `irq_o` and is granted on acknowledge (nesting).
- R7: Two opcode fetches in a row (`m1_i` high) carrying 0xED and then 0x4D end service for the lowest-index in-service source. This takes effect at the edge of the 0x4D fetch and only if `ien_i` is high. Cycles with `m1_i` low between the two fetches do not break the sequence. A fetch of any other byte between them does.
- R8: A cycle with `vec_we_i[i]` high loads `vec_wdata_i` as the vector of source i. Bit 0 of the delivered vector is always 0, whatever value was written.
- R9: An acknowledge while `ien_i` is low, or while no source is eligible, leaves `vec_oe_o` and `vec_o` at 0 and changes no pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_i | input | 1 | Chain enable from the higher-priority neighbour |
| req_i | input | NUM_SRC | One-cycle request pulses, bit 0 highest priority |
| iack_i | input | 1 | Interrupt acknowledge cycle strobe |
| m1_i | input | 1 | Opcode fetch strobe qualifying `data_i` |
| data_i | input | 8 | CPU data bus |
| vec_we_i | input | NUM_SRC | Per-source vector write enable |
| vec_wdata_i | input | 8 | Vector write value |
| irq_o | output | 1 | Interrupt request to the CPU, active high |
| ien_o | output | 1 | Chain enable to the lower-priority neighbour |
| vec_o | output | 8 | Vector driven during acknowledge, 0 otherwise |
| vec_oe_o | output | 1 | High when `vec_o` carries a valid vector |

## Verification
The vector and its valid flag are combinational in the acknowledge cycle itself. The bench drives `iack_i` 1 ns after a rising edge and reads `vec_o` 1 ns later, before the next edge. Everything registered (pending and in-service state, and so `irq_o` and `ien_o`) responds at the first rising edge after the request pulse, the acknowledge, or the closing 0x4D fetch. The bench therefore checks these outputs 1 ns after that edge, with no extra wait. A near-exhaustive sweep runs all 256 vector values through request, nested blocking and return, for both sources. Further sweeps cover every request pattern against both chain-enable levels, and the broken, delayed and disabled return sequences.

// File: rtl/ichain_pkg.sv
// Package: shared constants for the daisy-chain interrupt controller.
// Assumes an 8-bit CPU data bus and a two-byte return opcode.
package ichain_pkg;
    localparam int          VEC_W     = 8;
    localparam logic [7:0]  OP_PREFIX = 8'hED;
    localparam logic [7:0]  OP_RETURN = 8'h4D;
endpackage

// File: rtl/ichain_vecregs.sv
// Module: per-source vector storage and acknowledge read mux.
// Assumes sel_i is one-hot or zero; the output forces bit 0 to zero.
module ichain_vecregs #(
    parameter int NUM_SRC = 2,
    parameter int VEC_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] we_i,
    input  logic [VEC_W-1:0]   wdata_i,
    input  logic [NUM_SRC-1:0] sel_i,
    output logic [VEC_W-1:0]   vec_o
);
    logic [VEC_W-1:0] vec_q [NUM_SRC];
    logic [VEC_W-1:0] part  [NUM_SRC];

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            // Hold the vector of source g; load on its write enable.
            always_ff @(posedge clk) begin
                if (!rst_n)      vec_q[g] <= '0;
                else if (we_i[g]) vec_q[g] <= wdata_i;
            end
            // Contribute this vector only when the source is selected.
            always_comb part[g] = sel_i[g] ? vec_q[g] : '0;
        end
    endgenerate

    // OR the gated vectors together and clear the low bit.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NUM_SRC; i++) vec_o = vec_o | part[i];
        vec_o[0] = 1'b0;
    end
endmodule

// File: rtl/ichain_retdet.sv
// Module: return-from-interrupt detector on the opcode fetch stream.
// Assumes m1_i marks a cycle in which data_i holds an opcode byte.
module ichain_retdet
    import ichain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       m1_i,
    input  logic [7:0] data_i,
    output logic       ret_o
);
    logic prefix_q;

    // Remember whether the most recent opcode fetch was the prefix byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    prefix_q <= 1'b0;
        else if (m1_i) prefix_q <= (data_i == OP_PREFIX);
    end

    // Flag the return when the second byte follows the prefix.
    always_comb ret_o = m1_i && (data_i == OP_RETURN) && prefix_q;

    AST_PREFIX_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        ret_o |=> !prefix_q); // R7
endmodule

// File: rtl/ichain_tracker.sv
// Module: pending / in-service state and priority arbitration per source.
// Assumes index 0 is the highest priority; reqs are one-cycle pulses.
module ichain_tracker #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ien_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               ack_i,
    input  logic               ret_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] svc_o
);
    logic [NUM_SRC-1:0] pend_q, svc_q;
    logic [NUM_SRC-1:0] blocked, elig, elig_above, svc_above, clr;
    logic               take, done;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_arb
            if (g == 0) begin : g_top
                // Highest source has nothing above it.
                always_comb begin
                    svc_above[g]  = 1'b0;
                    elig_above[g] = 1'b0;
                end
            end else begin : g_rest
                // Accumulate service and eligibility from sources above.
                always_comb begin
                    svc_above[g]  = svc_above[g-1]  | svc_q[g-1];
                    elig_above[g] = elig_above[g-1] | elig[g-1];
                end
            end
            // Derive blocking, eligibility, grant and clear for source g.
            always_comb begin
                blocked[g] = svc_above[g] | svc_q[g];
                elig[g]    = pend_q[g] & ~blocked[g];
                grant_o[g] = elig[g] & ~elig_above[g];
                clr[g]     = svc_q[g] & ~svc_above[g];
            end
        end
    endgenerate

    // Qualify acknowledge and return with the chain enable.
    always_comb begin
        take = ack_i & ien_i;
        done = ret_i & ien_i;
    end

    // Update pending and in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            svc_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~(grant_o & {NUM_SRC{take}})) | req_i;
            svc_q  <= (svc_q & ~(clr & {NUM_SRC{done}})) | (grant_o & {NUM_SRC{take}});
        end
    end

    always_comb begin
        pend_o = pend_q;
        svc_o  = svc_q;
    end

    AST_GRANT_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (grant_o != '0)) |=> ((svc_q & $past(grant_o)) == $past(grant_o))); // R4
    AST_SERVICE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((svc_q & ~$past(svc_q)) != '0) |-> $past(ack_i && ien_i)); // R5
    AST_SINGLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones($past(svc_q) & ~svc_q) <= 1)); // R7
endmodule

// File: rtl/ichain_ctrl.sv
// Module: top of the daisy-chain vectored interrupt controller.
// Assumes a synchronous active-low reset and an 8-bit vector bus.
module ichain_ctrl
    import ichain_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ien_i,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               iack_i,
    input  logic               m1_i,
    input  logic [7:0]         data_i,
    input  logic [NUM_SRC-1:0] vec_we_i,
    input  logic [VEC_W-1:0]   vec_wdata_i,
    output logic               irq_o,
    output logic               ien_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               vec_oe_o
);
    logic [NUM_SRC-1:0] grant, pend, svc;
    logic [VEC_W-1:0]   vec_sel;
    logic               ret_seen;

    ichain_retdet u_retdet (
        .clk    (clk),
        .rst_n  (rst_n),
        .m1_i   (m1_i),
        .data_i (data_i),
        .ret_o  (ret_seen)
    );

    ichain_tracker #(.NUM_SRC(NUM_SRC)) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_i   (ien_i),
        .req_i   (req_i),
        .ack_i   (iack_i),
        .ret_i   (ret_seen),
        .grant_o (grant),
        .pend_o  (pend),
        .svc_o   (svc)
    );

    ichain_vecregs #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_vecregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (vec_we_i),
        .wdata_i (vec_wdata_i),
        .sel_i   (grant),
        .vec_o   (vec_sel)
    );

    // Drive request, chain enable and acknowledge vector.
    always_comb begin
        irq_o    = ien_i & (grant != '0);
        ien_o    = ien_i & (pend == '0) & (svc == '0);
        vec_oe_o = iack_i & ien_i & (grant != '0);
        vec_o    = vec_oe_o ? vec_sel : '0;
    end

    AST_REQUEST_CLOSES_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !ien_o); // R2
    AST_ACK_KEEPS_CHAIN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe_o |=> !ien_o); // R4
endmodule

// File: tb/ichain_ctrl_bench.sv
module ichain_ctrl_bench;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ien_i = 1'b1;
    logic [NP-1:0] req_i = '0;
    logic          iack_i = 1'b0;
    logic          m1_i = 1'b0;
    logic [7:0]    data_i = 8'h4D;
    logic [NP-1:0] vec_we_i = '0;
    logic [7:0]    vec_wdata_i = '0;
    logic          irq_o, ien_o, vec_oe_o;
    logic [7:0]    vec_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ichain_ctrl #(.NUM_SRC(NP)) u_ichain_ctrl (
        .clk(clk), .rst_n(rst_n), .ien_i(ien_i), .req_i(req_i),
        .iack_i(iack_i), .m1_i(m1_i), .data_i(data_i),
        .vec_we_i(vec_we_i), .vec_wdata_i(vec_wdata_i),
        .irq_o(irq_o), .ien_o(ien_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ien_i = 1'b1; req_i = '0; iack_i = 1'b0;
        m1_i = 1'b0; data_i = 8'h4D; vec_we_i = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic write_vec(int p, logic [7:0] v);
        vec_we_i[p] = 1'b1; vec_wdata_i = v;
        step();
        vec_we_i = '0;
    endtask

    task automatic raise(logic [NP-1:0] p);
        req_i = p;
        step();
        req_i = '0;
    endtask

    task automatic ack_check(string rq, bit exp_oe, logic [7:0] exp_v);
        iack_i = 1'b1;
        #1;
        chk(rq, 32'(vec_oe_o), 32'(exp_oe));
        chk(rq, 32'(vec_o), 32'(exp_oe ? exp_v : 8'h00));
        step();
        iack_i = 1'b0;
    endtask

    task automatic fetch(logic [7:0] op);
        m1_i = 1'b1; data_i = op;
        step();
        m1_i = 1'b0; data_i = 8'h4D;
    endtask

    task automatic ret_seq();
        fetch(8'hED);
        fetch(8'h4D);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 ien_o", 32'(ien_o), 1);
        chk("R1 vec_oe", 32'(vec_oe_o), 0);

        // R4 R5 R7 R8: sweep every vector value through nested service
        for (int v = 0; v < 256; v++) begin
            write_vec(0, 8'(v));
            write_vec(1, ~8'(v));
            raise(2'b11);
            chk("R2 irq", 32'(irq_o), 1);
            chk("R2 ien_o", 32'(ien_o), 0);
            ack_check("R4 src0 wins", 1'b1, 8'(v) & 8'hFE);
            chk("R5 irq blocked", 32'(irq_o), 0);
            ack_check("R5 no grant", 1'b0, 8'h00);
            ret_seq();
            chk("R7 src1 free", 32'(irq_o), 1);
            ack_check("R8 vector", 1'b1, ~8'(v) & 8'hFE);
            ret_seq();
            chk("R7 chain open", 32'(ien_o), 1);
            chk("R7 irq idle", 32'(irq_o), 0);
        end

        // R3 R9: every request pattern against both enable levels
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 2; e++) begin
                do_reset();
                write_vec(0, 8'h31);
                write_vec(1, 8'h74);
                ien_i = e[0];
                raise(2'(p));
                chk("R3 irq", 32'(irq_o), 32'(e == 1 && p != 0));
                chk("R3 ien_o", 32'(ien_o), 32'(e == 1 && p == 0));
                if (e == 0) begin
                    ack_check("R9 disabled ack", 1'b0, 8'h00);
                    ien_i = 1'b1;
                    #1;
                    chk("R9 pending kept", 32'(irq_o), 32'(p != 0));
                    if (p != 0)
                        ack_check("R9 later grant", 1'b1, (p & 1) ? 8'h30 : 8'h74);
                end
            end
        end

        // R6: higher source nests over lower one in service
        do_reset();
        write_vec(0, 8'h21);
        write_vec(1, 8'h62);
        raise(2'b10);
        ack_check("R4 src1", 1'b1, 8'h62);
        chk("R5 idle", 32'(irq_o), 0);
        raise(2'b01);
        chk("R6 nest irq", 32'(irq_o), 1);
        ack_check("R6 nest vec", 1'b1, 8'h20);
        ret_seq();
        chk("R7 inner done", 32'(ien_o), 0);
        chk("R7 no irq", 32'(irq_o), 0);
        ret_seq();
        chk("R7 outer done", 32'(ien_o), 1);

        // R7: broken, delayed and disabled return sequences
        do_reset();
        write_vec(0, 8'h10);
        raise(2'b01);
        ack_check("R4 src0", 1'b1, 8'h10);
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        chk("R7 broken", 32'(ien_o), 0);
        fetch(8'hED);
        data_i = 8'h00;
        repeat (3) step();
        fetch(8'h4D);
        chk("R7 delayed", 32'(ien_o), 1);
        raise(2'b01);
        ack_check("R4 again", 1'b1, 8'h10);
        ien_i = 1'b0;
        ret_seq();
        ien_i = 1'b1;
        #1;
        chk("R7 disabled ignored", 32'(ien_o), 0);
        ret_seq();
        chk("R7 enabled", 32'(ien_o), 1);

        summary();
    end
endmodule